// File: doc/BRIEF.md
# Delta-Sigma Converter Command Sequencer

This block sits on the host side of a four-wire SPI link to a multiplexed delta-sigma converter. A start pulse launches one complete configure-and-measure pass. The block first waits for the converter's active-low ready line to go low. It then keeps chip select low for the whole pass and sends, in order: the stop-continuous-readout opcode, three register writes (data rate, control, input multiplexer), the resynchronise opcode, the wake opcode and the read-data opcode. After that it clocks in a 24-bit sample. The three configuration values come from plain inputs and are captured on the accepted start.

The pacing comes from the converter's master clock and not from the SPI engine. Each SCLK phase lasts at least two master clocks. After specific opcodes the block holds a fixed silence, counted in master clocks, before the next SCLK edge. Before the read-data opcode it waits for the ready line again. All lengths are parameters, given as master-clock counts together with the ratio of host clock to master clock.

The state machine has seven states. `ST_IDLE` goes to `ST_WAIT_READY` on start. `ST_WAIT_READY` goes to `ST_ISSUE` once the ready line is low, and chip select drops at that point. `ST_ISSUE` always goes to `ST_SHIFT`. `ST_SHIFT` goes to `ST_GAP` when the byte that just ended needs a silence, and otherwise it advances. `ST_GAP` advances when the timer runs out. To advance means going to `ST_WAIT_DATA` after the wake opcode, to `ST_FINISH` after the third sample byte, and to `ST_ISSUE` in every other case. `ST_WAIT_DATA` goes to `ST_ISSUE` once the ready line is low. `ST_FINISH` raises chip select, pulses the result strobe and returns to `ST_IDLE`.

Top module: `adc_cmd_seq`

## Requirements
- R1: After an accepted start, chip select stays high and SCLK stays low until drdy_n is sampled low. Chip select falls only in the cycle after drdy_n was seen low.
- R2: One pass sends exactly these 16 bytes on MOSI, MSB first: 0x0F, 0x53, 0x00, drate, 0x52, 0x00, adcon, 0x51, 0x00, mux, 0xFC, 0x00, 0x01, 0x00, 0x00, 0x00. A register write is 0x50 plus the register address (3 is data rate, 2 is control, 1 is multiplexer), then 0x00 for a count of one, then the value.
- R3: SPI mode 1. SCLK idles low. MOSI changes only as SCLK rises and holds steady while SCLK is high. MISO is sampled as SCLK falls. SCLK toggles only while chip select is low.
- R4: Every SCLK high phase and every low phase inside a byte lasts at least SCLK_HALF_MCLK × MCLK_RATIO host clocks. With the defaults that is 4 host clocks, so a period of at least 4 master clocks.
- R5: After the stop opcode, after the wake opcode and after the data byte of each register write, at least GAP_WREG_MCLK (or GAP_CMD_MCLK) master clocks pass between the byte's last falling SCLK edge and the next rising edge.
- R6: After the resynchronise opcode (0xFC), at least GAP_SYNC_MCLK (24) master clocks pass before the wake opcode starts.
- R7: After the read-data opcode (0x01), at least GAP_READ_MCLK (50) master clocks pass before the first sample clock.
- R8: The read-data opcode does not start until drdy_n has been sampled low after the wake opcode has ended.
- R9: result holds the three sample bytes, first byte in bits 23:16. result_valid is high for exactly one cycle, with chip select already high in that cycle.
- R10: busy is high from the cycle after an accepted start up to the cycle of result_valid. A start pulse while busy is ignored and does not cause another pass.
- R11: Out of reset, spi_cs_n is 1, spi_sclk is 0, spi_mosi is 0, busy is 0 and result_valid is 0.
- R12: The configuration inputs are captured on the accepted start. Changes to them during the pass have no effect on the bytes sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one configure-and-read pass |
| cfg_drate | input | 8 | Value for the data-rate register |
| cfg_adcon | input | 8 | Value for the control register |
| cfg_mux | input | 8 | Value for the input multiplexer register |
| drdy_n | input | 1 | Converter ready line, active low |
| spi_miso | input | 1 | Serial data from the converter |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the converter |
| busy | output | 1 | Pass in progress |
| result_valid | output | 1 | One-cycle strobe for result |
| result | output | 24 | Sample word, first byte in the top bits |

## Verification
Each byte takes 16 × SCLK_HALF_MCLK × MCLK_RATIO host clocks (64 with the defaults). The silence after a byte is timed from its last falling SCLK edge, and result_valid arrives a few cycles after the last sample bit. For these reasons the bench never samples a fixed cycle. It samples every output on the falling host edge. It recovers each MOSI bit on the falling SCLK edge and pops the expected byte at the eighth bit. It stamps the cycle of every SCLK edge, so phase widths and silences are compared against their master-clock minimums as intervals. A lower-bound check holds however many register stages sit on the path. The sample word and its strobe are scored when result_valid shows up. The ready line is released a fixed 40 cycles after the wake opcode, so that any read-data opcode sent before that point is flagged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int STEP_W          = 4;
    localparam int LAST_CMD_STEP   = 11;
    localparam int FIRST_READ_STEP = 13;
    localparam int FINAL_STEP      = 15;

    localparam logic [7:0] OP_STOP_CONT = 8'h0F;
    localparam logic [7:0] OP_WRITE_REG = 8'h50;
    localparam logic [7:0] OP_RESYNC    = 8'hFC;
    localparam logic [7:0] OP_WAKE      = 8'h00;
    localparam logic [7:0] OP_READ_DATA = 8'h01;

    localparam logic [7:0] ADDR_RATE = 8'h03;
    localparam logic [7:0] ADDR_CTRL = 8'h02;
    localparam logic [7:0] ADDR_MUX  = 8'h01;

    typedef enum logic [2:0] {
        GAP_NONE,
        GAP_CMD,
        GAP_WREG,
        GAP_SYNC,
        GAP_READ
    } gap_kind_t;

    function automatic logic [7:0] step_byte(input logic [STEP_W-1:0] step,
                                             input logic [7:0] drate,
                                             input logic [7:0] adcon,
                                             input logic [7:0] mux);
        logic [7:0] b;
        case (step)
            4'd0:    b = OP_STOP_CONT;
            4'd1:    b = OP_WRITE_REG | ADDR_RATE;
            4'd3:    b = drate;
            4'd4:    b = OP_WRITE_REG | ADDR_CTRL;
            4'd6:    b = adcon;
            4'd7:    b = OP_WRITE_REG | ADDR_MUX;
            4'd9:    b = mux;
            4'd10:   b = OP_RESYNC;
            4'd11:   b = OP_WAKE;
            4'd12:   b = OP_READ_DATA;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

    function automatic gap_kind_t step_gap(input logic [STEP_W-1:0] step);
        gap_kind_t g;
        case (step)
            4'd0, 4'd11:       g = GAP_CMD;
            4'd3, 4'd6, 4'd9:  g = GAP_WREG;
            4'd10:             g = GAP_SYNC;
            4'd12:             g = GAP_READ;
            default:           g = GAP_NONE;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int CW = $clog2(HALF_CLKS + 1);

    typedef enum logic [1:0] {PH_IDLE, PH_HIGH, PH_LOW} phase_t;

    phase_t        ph;
    logic [CW-1:0] cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    sh;
    logic          half_end;

    assign half_end = (cnt == CW'(HALF_CLKS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph      <= PH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            sh      <= '0;
            sclk    <= 1'b0;
            mosi    <= 1'b0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            done <= 1'b0;
            unique case (ph)
                PH_IDLE: begin
                    if (go) begin
                        sh      <= {tx_byte[6:0], 1'b0};
                        mosi    <= tx_byte[7];
                        sclk    <= 1'b1;
                        cnt     <= '0;
                        bit_idx <= '0;
                        ph      <= PH_HIGH;
                    end
                end
                PH_HIGH: begin
                    if (half_end) begin
                        sclk    <= 1'b0;
                        rx_byte <= {rx_byte[6:0], miso};
                        cnt     <= '0;
                        ph      <= PH_LOW;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOW: begin
                    if (half_end) begin
                        cnt <= '0;
                        if (bit_idx == 3'd7) begin
                            done <= 1'b1;
                            ph   <= PH_IDLE;
                        end else begin
                            bit_idx <= bit_idx + 1'b1;
                            mosi    <= sh[7];
                            sh      <= {sh[6:0], 1'b0};
                            sclk    <= 1'b1;
                            ph      <= PH_HIGH;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/gap_counter.sv
module gap_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);

    logic [W-1:0] cnt;

    assign expired = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= len - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
    import adc_seq_pkg::*;
#(
    parameter int MCLK_RATIO     = 2,
    parameter int SCLK_HALF_MCLK = 2,
    parameter int GAP_CMD_MCLK   = 4,
    parameter int GAP_WREG_MCLK  = 4,
    parameter int GAP_SYNC_MCLK  = 24,
    parameter int GAP_READ_MCLK  = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [7:0]  cfg_drate,
    input  logic [7:0]  cfg_adcon,
    input  logic [7:0]  cfg_mux,
    input  logic        drdy_n,
    input  logic        spi_miso,
    output logic        spi_cs_n,
    output logic        spi_sclk,
    output logic        spi_mosi,
    output logic        busy,
    output logic        result_valid,
    output logic [23:0] result
);

    localparam int HALF     = SCLK_HALF_MCLK * MCLK_RATIO;
    localparam int LEN_CMD  = GAP_CMD_MCLK * MCLK_RATIO;
    localparam int LEN_WREG = GAP_WREG_MCLK * MCLK_RATIO;
    localparam int LEN_SYNC = GAP_SYNC_MCLK * MCLK_RATIO;
    localparam int LEN_READ = GAP_READ_MCLK * MCLK_RATIO;
    localparam int MAX_AB   = (LEN_CMD > LEN_WREG) ? LEN_CMD : LEN_WREG;
    localparam int MAX_CD   = (LEN_SYNC > LEN_READ) ? LEN_SYNC : LEN_READ;
    localparam int MAX_LEN  = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int TW       = $clog2(MAX_LEN + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_READY,
        ST_ISSUE,
        ST_SHIFT,
        ST_GAP,
        ST_WAIT_DATA,
        ST_FINISH
    } state_t;

    state_t            state, nxt, follow;
    logic [STEP_W-1:0] step;
    logic [7:0]        drate_q, adcon_q, mux_q;
    logic [23:0]       acc;
    gap_kind_t         kind;

    logic              eng_go, eng_done;
    logic [7:0]        eng_tx, eng_rx;
    logic              tmr_load, tmr_expired;
    logic [TW-1:0]     tmr_len;
    logic              advance;

    assign kind     = step_gap(step);
    assign eng_tx   = step_byte(step, drate_q, adcon_q, mux_q);
    assign eng_go   = (state == ST_ISSUE);
    assign tmr_load = (state == ST_SHIFT) && eng_done;
    assign advance  = ((state == ST_SHIFT) && eng_done && (kind == GAP_NONE)) ||
                      ((state == ST_GAP) && tmr_expired);

    always_comb begin
        unique case (kind)
            GAP_CMD:  tmr_len = TW'(LEN_CMD);
            GAP_WREG: tmr_len = TW'(LEN_WREG);
            GAP_SYNC: tmr_len = TW'(LEN_SYNC);
            GAP_READ: tmr_len = TW'(LEN_READ);
            default:  tmr_len = TW'(1);
        endcase
    end

    spi_byte_shifter #(.HALF_CLKS(HALF)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (eng_go),
        .tx_byte (eng_tx),
        .miso    (spi_miso),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi),
        .done    (eng_done),
        .rx_byte (eng_rx)
    );

    gap_counter #(.W(TW)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_expired)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        if (step == STEP_W'(LAST_CMD_STEP))   follow = ST_WAIT_DATA;
        else if (step == STEP_W'(FINAL_STEP)) follow = ST_FINISH;
        else                                  follow = ST_ISSUE;

        nxt = state;
        unique case (state)
            ST_IDLE:       if (start) nxt = ST_WAIT_READY;
            ST_WAIT_READY: if (!drdy_n) nxt = ST_ISSUE;
            ST_ISSUE:      nxt = ST_SHIFT;
            ST_SHIFT: begin
                if (eng_done) nxt = (kind == GAP_NONE) ? follow : ST_GAP;
            end
            ST_GAP:        if (tmr_expired) nxt = follow;
            ST_WAIT_DATA:  if (!drdy_n) nxt = ST_ISSUE;
            ST_FINISH:     nxt = ST_IDLE;
            default:       nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step         <= '0;
            drate_q      <= '0;
            adcon_q      <= '0;
            mux_q        <= '0;
            acc          <= '0;
            spi_cs_n     <= 1'b1;
            busy         <= 1'b0;
            result_valid <= 1'b0;
            result       <= '0;
        end else begin
            result_valid <= 1'b0;
            if (state == ST_IDLE && start) begin
                step    <= '0;
                drate_q <= cfg_drate;
                adcon_q <= cfg_adcon;
                mux_q   <= cfg_mux;
                busy    <= 1'b1;
            end
            if (state == ST_WAIT_READY && !drdy_n) spi_cs_n <= 1'b0;
            if (state == ST_SHIFT && eng_done && step >= STEP_W'(FIRST_READ_STEP))
                acc <= {acc[15:0], eng_rx};
            if (advance) step <= step + 1'b1;
            if (state == ST_FINISH) begin
                spi_cs_n     <= 1'b1;
                busy         <= 1'b0;
                result_valid <= 1'b1;
                result       <= acc;
            end
        end
    end

endmodule

// File: rtl/adc_cmd_seq_chk.sv
module adc_cmd_seq_chk #(
    parameter int HALF = 4
) (
    input logic clk,
    input logic rst_n,
    input logic drdy_n,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic spi_mosi,
    input logic busy,
    input logic result_valid
);

    logic [15:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hi_len <= '0;
        else if (spi_sclk) hi_len <= hi_len + 1'b1;
        else               hi_len <= '0;
    end

    a_r1_cs_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> !$past(drdy_n));

    a_r3_sclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        spi_sclk |-> !spi_cs_n);

    a_r3_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

    a_r4_sclk_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sclk) |-> (hi_len >= 16'(HALF)));

    a_r9_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r9_valid_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (spi_cs_n && !busy));

    a_r10_busy_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_cs_n |-> busy);

endmodule

bind adc_cmd_seq adc_cmd_seq_chk #(.HALF(HALF)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .drdy_n       (drdy_n),
    .spi_cs_n     (spi_cs_n),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .busy         (busy),
    .result_valid (result_valid)
);

// File: tb/sim_adc_cmd_seq.sv
`timescale 1ns/1ps
module sim_adc_cmd_seq;

    localparam int RATIO = 2;
    localparam int HALF  = 2 * RATIO;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cfg_drate = 8'h00, cfg_adcon = 8'h00, cfg_mux = 8'h00;
    logic        drdy_n;
    logic        spi_miso = 1'b0;
    logic        spi_cs_n, spi_sclk, spi_mosi, busy, result_valid;
    logic [23:0] result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int results_seen = 0;

    logic [7:0]  exp_bytes[$];
    logic [23:0] exp_res[$];
    logic [23:0] slave_word = 24'h0;
    logic        drv_block = 1'b1;
    int          rel_cnt = 0;

    assign drdy_n = drv_block | (rel_cnt != 0);

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_cmd_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_drate(cfg_drate), .cfg_adcon(cfg_adcon), .cfg_mux(cfg_mux),
        .drdy_n(drdy_n), .spi_miso(spi_miso),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
        .busy(busy), .result_valid(result_valid), .result(result)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int gap_need(input int idx);
        case (idx)
            0, 11, 3, 6, 9: return 4 * RATIO;
            10:             return 24 * RATIO;
            12:             return 50 * RATIO;
            default:        return 0;
        endcase
    endfunction

    // slave model and byte scoreboard
    logic       prev_sclk = 1'b0;
    int         bitcnt = 0, byte_idx = 0, rise_cyc = 0, fall_cyc = 0, last_fall = 0;
    logic [7:0] rx_sh = 8'h00;
    logic [23:0] rd_word = 24'h0;
    bit         ready_seen = 1'b0;
    logic       prev_valid = 1'b0;

    always @(negedge clk) begin
        if (rel_cnt != 0) begin
            if (rel_cnt == 1) ready_seen <= 1'b1;
            rel_cnt <= rel_cnt - 1;
        end
        if (rst_n) begin
            if (spi_cs_n) begin
                byte_idx <= 0;
                bitcnt   <= 0;
            end
            if (spi_sclk && !prev_sclk) begin
                check(!spi_cs_n, "R3 sclk with cs high", {31'd0, spi_cs_n}, 0);
                if (bitcnt == 0 && byte_idx > 0 && gap_need(byte_idx - 1) > 0) begin
                    if (byte_idx == 12) check(ready_seen, "R8 read opcode before ready", 0, 1);
                    if (byte_idx == 11)
                        check(cyc - last_fall >= gap_need(10), "R6 resync gap",
                              cyc - last_fall, gap_need(10));
                    else if (byte_idx == 13)
                        check(cyc - last_fall >= gap_need(12), "R7 read gap",
                              cyc - last_fall, gap_need(12));
                    else
                        check(cyc - last_fall >= gap_need(byte_idx - 1), "R5 command gap",
                              cyc - last_fall, gap_need(byte_idx - 1));
                end
                if (bitcnt != 0)
                    check(cyc - fall_cyc >= HALF, "R4 low phase", cyc - fall_cyc, HALF);
                if (byte_idx >= 13) begin
                    spi_miso <= rd_word[23];
                    rd_word  <= {rd_word[22:0], 1'b0};
                end
                rise_cyc <= cyc;
            end
            if (!spi_sclk && prev_sclk) begin
                check(cyc - rise_cyc >= HALF, "R4 high phase", cyc - rise_cyc, HALF);
                fall_cyc <= cyc;
                if (bitcnt == 7) begin
                    logic [7:0] got;
                    got = {rx_sh[6:0], spi_mosi};
                    if (exp_bytes.size() == 0) begin
                        check(0, "R2 unexpected byte", got, 0);
                    end else begin
                        logic [7:0] want;
                        want = exp_bytes.pop_front();
                        check(got == want, "R2 R3 R12 byte", got, want);
                    end
                    last_fall <= cyc;
                    bitcnt    <= 0;
                    byte_idx  <= byte_idx + 1;
                    if (byte_idx == 11) begin
                        rel_cnt    <= 40;
                        ready_seen <= 1'b0;
                    end
                    if (byte_idx == 12) rd_word <= slave_word;
                end else begin
                    bitcnt <= bitcnt + 1;
                end
                rx_sh <= {rx_sh[6:0], spi_mosi};
            end
            if (result_valid) begin
                logic [23:0] want_r;
                want_r = (exp_res.size() != 0) ? exp_res.pop_front() : 24'hxxxxxx;
                check(result === want_r, "R9 result word", result, want_r);
                check(spi_cs_n && !busy, "R9 R10 cs and busy at strobe", {spi_cs_n, busy}, 2'b10);
                results_seen <= results_seen + 1;
            end
            if (prev_valid)
                check(!result_valid, "R9 strobe width", {31'd0, result_valid}, 0);
            prev_valid <= result_valid;
        end
        prev_sclk <= spi_sclk;
    end

    task automatic run_pass(input logic [7:0] d, input logic [7:0] a, input logic [7:0] m,
                            input logic [23:0] word, input bit disturb);
        int base;
        exp_bytes.push_back(8'h0F); exp_bytes.push_back(8'h53); exp_bytes.push_back(8'h00);
        exp_bytes.push_back(d);
        exp_bytes.push_back(8'h52); exp_bytes.push_back(8'h00); exp_bytes.push_back(a);
        exp_bytes.push_back(8'h51); exp_bytes.push_back(8'h00); exp_bytes.push_back(m);
        exp_bytes.push_back(8'hFC); exp_bytes.push_back(8'h00); exp_bytes.push_back(8'h01);
        exp_bytes.push_back(8'h00); exp_bytes.push_back(8'h00); exp_bytes.push_back(8'h00);
        exp_res.push_back(word);
        slave_word = word;
        base = results_seen;
        drv_block = 1'b1;
        @(negedge clk);
        cfg_drate = d; cfg_adcon = a; cfg_mux = m;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            cfg_drate = ~d; cfg_adcon = ~a; cfg_mux = ~m;   // R12
        end
        check(busy, "R10 busy after start", {31'd0, busy}, 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(spi_cs_n && !spi_sclk, "R1 idle before ready", {spi_cs_n, spi_sclk}, 2'b10);
        end
        drv_block = 1'b0;
        if (disturb) begin
            repeat (200) @(negedge clk);
            start = 1'b1;                                   // R10 ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (results_seen == base) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(spi_cs_n && !spi_sclk && !spi_mosi && !busy && !result_valid,
              "R11 reset state", {spi_cs_n, spi_sclk, spi_mosi, busy, result_valid}, 5'b10000);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(spi_cs_n && !busy, "R11 idle after reset", {spi_cs_n, busy}, 2'b10);

        run_pass(8'hA1, 8'h20, 8'h01, 24'h5A3C81, 1'b0);
        run_pass(8'h82, 8'h27, 8'h23, 24'hFF0001, 1'b1);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            check(spi_cs_n && !busy, "R10 no extra pass", {spi_cs_n, busy}, 2'b10);
        end
        run_pass(8'h03, 8'hFF, 8'h80, 24'h800000, 1'b0);
        check(exp_bytes.size() == 0, "R2 all bytes sent", exp_bytes.size(), 0);
        check(exp_res.size() == 0, "R9 all results seen", exp_res.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        while (cyc < 150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule